// File: doc/BRIEF.md
# Byte-Serial Header Checksum Accumulator

This block keeps a running 16-bit ones' complement sum over a header that arrives one byte at a time. Bytes are taken in pairs: the first byte of a pair becomes the upper half of a 16-bit word and the second becomes the lower half. Each finished word is added into the sum with end-around carry. The carry out of the 17-bit addition is folded back in the same cycle, so the stored sum is always a proper 16-bit ones' complement value.

A producer holds a strobe high while a byte is present. The block counts a byte only on the clock where the strobe rises, so a strobe held for several cycles counts once. A synchronous clear starts a new header. A flush input closes an odd-length stream by pairing the last byte with a zero low byte. The sum is visible at all times. A flag reports when the sum is all-ones, which is the result an intact header gives once its own checksum field has been summed.

Top module: `hdr_csum16`

## Requirements
- R1: While reset (rst_n low, asynchronous) is held and right after it is released, sum_out is 0x0000, sum_ok is 0, the block waits for a high byte, and the remembered strobe is 0. A strobe that is already high on the first clock after release therefore counts as a byte.
- R2: A byte is taken only on a clock where byte_stb is 1 and was 0 on the clock before. A strobe held high for several clocks adds exactly one byte.
- R3: Bytes alternate between a high phase and a low phase. The byte taken in the high phase forms bits [15:8] of the word and the next byte forms bits [7:0].
- R4: When a low-phase byte is taken, sum_out shows the new sum after that same clock edge. The new sum is the 17-bit sum of the old value and the word, with bit 16 added back into bits [15:0].
- R5: hdr_clear set to 1 on a clock makes sum_out 0x0000 and returns to the high phase. It wins over a byte taken on the same clock, and that byte is dropped.
- R6: When a strobe is held high across a clear, it does not count again after the clear. The strobe history keeps updating during a clear.
- R7: flush set to 1 in the low phase, on a clock where no byte is taken and no clear occurs, adds {held byte, 0x00} and returns to the high phase. In the high phase, flush has no effect on sum_out or on the pairing.
- R8: sum_ok is 1 exactly when sum_out equals 0xFFFF.
- R9: For a 20-byte header whose checksum field holds the correct value, the final sum is 0xFFFF. Changing any one byte gives a sum other than 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_clear | input | 1 | Synchronous start of a new header |
| byte_stb | input | 1 | Level strobe; a rising edge marks a new byte |
| byte_in | input | 8 | Header byte |
| flush | input | 1 | Pad a pending high byte with a zero low byte |
| sum_out | output | 16 | Running ones' complement sum |
| sum_ok | output | 1 | Sum equals 0xFFFF |

## Verification
The bench goes after these corner cases:

- **Held strobe.** A strobe held for several cycles must count once. A level-sensitive design would add the byte again.
- **Carry fold.** Word pairs whose sum carries out of bit 15 are fed in. A design that drops the carry, or folds it a cycle late, shows the wrong sum on the very next clock.
- **Odd-length streams.** Flush is applied in both phases. Swapping the halves of the padded word, or acting on flush in the high phase, changes the sum.
- **Clear.** A clear arrives in the middle of a word, in the same cycle as a strobe edge, and while the strobe is still held. A design that keeps the phase, or re-counts the held byte after the clear, drifts from the reference.
- **Full headers.** Whole valid headers and corrupted ones are summed, to show whether the ok flag separates them.

// File: rtl/hdr_csum16_pkg.sv
package hdr_csum16_pkg;

    localparam int unsigned CSUM_BYTE_W = 8;

    typedef enum logic {
        PH_HIGH = 1'b0,
        PH_LOW  = 1'b1
    } pair_phase_e;

endpackage

// File: rtl/hcs_edge.sv
module hcs_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    output logic stb_rise
);

    typedef struct packed {
        logic prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = stb;
        stb_rise  = stb & ~st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/hcs_pack.sv
module hcs_pack
    import hdr_csum16_pkg::*;
#(
    parameter int unsigned BYTE_W = CSUM_BYTE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                take,
    input  logic                flush,
    input  logic [BYTE_W-1:0]   byte_in,
    output logic                word_vld,
    output logic [2*BYTE_W-1:0] word,
    output logic                phase_lo
);

    localparam int unsigned WORD_W = 2 * BYTE_W;

    typedef struct packed {
        pair_phase_e       phase;
        logic [BYTE_W-1:0] held;
    } pack_st_t;

    pack_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        word_vld = 1'b0;
        word     = '0;
        if (clear) begin
            st_d.phase = PH_HIGH;
        end else if (take) begin
            if (st_q.phase == PH_HIGH) begin
                st_d.held  = byte_in;
                st_d.phase = PH_LOW;
            end else begin
                word_vld   = 1'b1;
                word       = {st_q.held, byte_in};
                st_d.phase = PH_HIGH;
            end
        end else if (flush && st_q.phase == PH_LOW) begin
            word_vld   = 1'b1;
            word       = {st_q.held, {BYTE_W{1'b0}}};
            st_d.phase = PH_HIGH;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_HIGH, held: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_lo = (st_q.phase == PH_LOW);

    logic [WORD_W-1:0] unused_w;
    assign unused_w = word;

endmodule

// File: rtl/hcs_fold_add.sv
module hcs_fold_add #(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              word_vld,
    input  logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] sum
);

    localparam int unsigned WIDE_W = WORD_W + 1;

    typedef struct packed {
        logic [WORD_W-1:0] acc;
    } add_st_t;

    add_st_t           st_d, st_q;
    logic [WIDE_W-1:0] wide;
    logic [WORD_W-1:0] folded;

    always_comb begin
        st_d   = st_q;
        wide   = {1'b0, st_q.acc} + {1'b0, word};
        folded = wide[WORD_W-1:0] + WORD_W'(wide[WORD_W]);
        if (clear) begin
            st_d.acc = '0;
        end else if (word_vld) begin
            st_d.acc = folded;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sum = st_q.acc;

endmodule

// File: rtl/hdr_csum16.sv
module hdr_csum16
    import hdr_csum16_pkg::*;
#(
    parameter int unsigned BYTE_W = CSUM_BYTE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hdr_clear,
    input  logic                byte_stb,
    input  logic [BYTE_W-1:0]   byte_in,
    input  logic                flush,
    output logic [2*BYTE_W-1:0] sum_out,
    output logic                sum_ok
);

    localparam int unsigned WORD_W = 2 * BYTE_W;

    logic              stb_edge;
    logic              word_vld;
    logic [WORD_W-1:0] word;
    logic              phase_lo;

    hcs_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb      (byte_stb),
        .stb_rise (stb_edge)
    );

    hcs_pack #(.BYTE_W(BYTE_W)) u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (hdr_clear),
        .take     (stb_edge),
        .flush    (flush),
        .byte_in  (byte_in),
        .word_vld (word_vld),
        .word     (word),
        .phase_lo (phase_lo)
    );

    hcs_fold_add #(.WORD_W(WORD_W)) u_add (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (hdr_clear),
        .word_vld (word_vld),
        .word     (word),
        .sum      (sum_out)
    );

    assign sum_ok = (sum_out == {WORD_W{1'b1}});

endmodule

// File: rtl/hdr_csum16_chk.sv
module hdr_csum16_chk #(
    parameter int unsigned WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hdr_clear,
    input logic              flush,
    input logic              stb_edge,
    input logic              phase_lo,
    input logic [WORD_W-1:0] sum_out
);

    // R2: with no byte edge, no clear and no effective flush, the sum holds
    a_r2_quiet_without_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (!hdr_clear && !stb_edge && !(flush && phase_lo)) |=> $stable(sum_out));

    // R5: clear zeroes the sum and returns to the high phase
    a_r5_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_clear |=> (sum_out == '0 && !phase_lo));

    // R4: an end-around-carry sum never wraps a nonzero value to zero
    a_r4_no_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!hdr_clear && sum_out != '0) |=> (sum_out != '0));

    // R3: every counted byte flips the phase
    a_r3_phase_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (!hdr_clear && stb_edge) |=> (phase_lo != $past(phase_lo)));

    // R7: a flush in the low phase returns to the high phase
    a_r7_flush_closes_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (!hdr_clear && !stb_edge && flush && phase_lo) |=> !phase_lo);

endmodule

bind hdr_csum16 hdr_csum16_chk #(.WORD_W(2 * BYTE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hdr_clear (hdr_clear),
    .flush     (flush),
    .stb_edge  (stb_edge),
    .phase_lo  (phase_lo),
    .sum_out   (sum_out)
);

// File: tb/hdr_csum16_test.sv
module hdr_csum16_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hdr_clear = 1'b0;
    logic        byte_stb = 1'b0;
    logic [7:0]  byte_in = 8'h00;
    logic        flush = 1'b0;
    logic [15:0] sum_out;
    logic        sum_ok;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // behavioural reference state
    bit          m_prev = 1'b0;
    bit          m_lo   = 1'b0;
    logic [7:0]  m_hi   = 8'h00;
    int          m_sum  = 0;

    always #10 clk = ~clk;

    hdr_csum16 uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .hdr_clear (hdr_clear),
        .byte_stb  (byte_stb),
        .byte_in   (byte_in),
        .flush     (flush),
        .sum_out   (sum_out),
        .sum_ok    (sum_ok)
    );

    function automatic int oc_add(input int a, input int w);
        int s;
        s = a + w;
        if (s > 65535) s = s - 65535;
        return s;
    endfunction

    task automatic expect_val(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        expect_val({tag, " sum"}, int'(sum_out), m_sum);
        expect_val({tag, " ok (R8)"}, int'(sum_ok), (m_sum == 65535) ? 1 : 0);
    endtask

    task automatic model(input bit clr, input bit stb, input bit fl, input logic [7:0] d);
        bit rise;
        rise   = stb && !m_prev;
        m_prev = stb;
        if (clr) begin
            m_sum = 0;
            m_lo  = 1'b0;
        end else if (rise) begin
            if (!m_lo) begin
                m_hi = d;
                m_lo = 1'b1;
            end else begin
                m_sum = oc_add(m_sum, {16'h0, m_hi, d});
                m_lo  = 1'b0;
            end
        end else if (fl && m_lo) begin
            m_sum = oc_add(m_sum, {16'h0, m_hi, 8'h00});
            m_lo  = 1'b0;
        end
    endtask

    // called at a falling edge; drives, lets one rising edge pass, compares
    task automatic step(input bit clr, input bit stb, input bit fl,
                        input logic [7:0] d, input string tag);
        hdr_clear = clr;
        byte_stb  = stb;
        flush     = fl;
        byte_in   = d;
        @(posedge clk);
        #1;
        model(clr, stb, fl, d);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic feed(input logic [7:0] d, input string tag);
        step(1'b0, 1'b1, 1'b0, d, tag);
        step(1'b0, 1'b0, 1'b0, d, tag);
    endtask

    task automatic do_reset(input bit stb_during);
        @(negedge clk);
        rst_n    = 1'b0;
        byte_stb = stb_during;
        hdr_clear = 1'b0;
        flush    = 1'b0;
        m_prev = 1'b0; m_lo = 1'b0; m_sum = 0;
        @(negedge clk);
        expect_val("R1 reset sum", int'(sum_out), 0);
        expect_val("R1 reset ok", int'(sum_ok), 0);
        rst_n = 1'b1;
    endtask

    task automatic run_header(input logic [7:0] h [20], input bit corrupt,
                              input int pos, input string tag);
        logic [7:0] b [20];
        int s;
        b = h;
        b[10] = 8'h00;
        b[11] = 8'h00;
        s = 0;
        for (int i = 0; i < 20; i += 2) s = oc_add(s, {16'h0, b[i], b[i+1]});
        s = (~s) & 16'hFFFF;
        b[10] = s[15:8];
        b[11] = s[7:0];
        if (corrupt) b[pos] = b[pos] ^ 8'h10;
        step(1'b1, 1'b0, 1'b0, 8'h00, {tag, " R5 clear"});
        for (int i = 0; i < 20; i++) feed(b[i], tag);
        expect_val({tag, " R9 final"}, (sum_out == 16'hFFFF) ? 1 : 0, corrupt ? 0 : 1);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] hdr_a [20];
        logic [7:0] hdr_b [20];
        hdr_a = '{8'h45, 8'h00, 8'h00, 8'h3c, 8'h1c, 8'h46, 8'h40, 8'h00, 8'h40, 8'h06,
                  8'h00, 8'h00, 8'hac, 8'h10, 8'h0a, 8'h63, 8'hac, 8'h10, 8'h0a, 8'h0c};
        hdr_b = '{8'h46, 8'hff, 8'hff, 8'hfe, 8'hf0, 8'h0f, 8'hff, 8'hff, 8'h01, 8'h11,
                  8'h00, 8'h00, 8'hff, 8'hff, 8'hfe, 8'hdc, 8'hc0, 8'ha8, 8'hff, 8'hff};

        // R1: reset state, then a strobe already high at release counts
        do_reset(1'b0);
        step(1'b0, 1'b0, 1'b0, 8'h00, "R1 idle");
        do_reset(1'b1);
        step(1'b0, 1'b1, 1'b0, 8'h12, "R1 first edge after reset");
        step(1'b0, 1'b1, 1'b0, 8'h34, "R2 held");
        step(1'b0, 1'b0, 1'b0, 8'h00, "R2 release");
        feed(8'h56, "R3 low byte");
        expect_val("R1 R3 word 0x1256", int'(sum_out), 16'h1256);

        // R2: held strobe over several cycles counts once
        step(1'b1, 1'b0, 1'b0, 8'h00, "R5 clear");
        step(1'b0, 1'b1, 1'b0, 8'hAB, "R2 rise");
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b0, 8'hEE, "R2 hold");
        step(1'b0, 1'b0, 1'b0, 8'h00, "R2 drop");
        feed(8'hCD, "R3 pair");
        expect_val("R2 R3 held strobe once", int'(sum_out), 16'hABCD);

        // R4: carry fold
        feed(8'hFF, "R4 hi");
        feed(8'h00, "R4 lo");
        expect_val("R4 fold 0xABCD+0xFF00", int'(sum_out), 16'hAACE);
        feed(8'h55, "R4 hi");
        feed(8'h31, "R4 lo");
        expect_val("R4 fold to 0xFFFF", int'(sum_out), 16'hFFFF);
        expect_val("R8 ok at 0xFFFF", int'(sum_ok), 1);
        feed(8'hFF, "R4 hi");
        feed(8'hFF, "R4 lo");
        expect_val("R4 0xFFFF+0xFFFF", int'(sum_out), 16'hFFFF);

        // R7: flush in high phase ignored, in low phase pads
        step(1'b1, 1'b0, 1'b0, 8'h00, "R5 clear");
        step(1'b0, 1'b0, 1'b1, 8'h00, "R7 flush high phase");
        expect_val("R7 flush high no effect", int'(sum_out), 0);
        feed(8'h9A, "R7 odd byte");
        step(1'b0, 1'b0, 1'b1, 8'h77, "R7 flush low phase");
        expect_val("R7 padded word", int'(sum_out), 16'h9A00);
        feed(8'h01, "R7 new pair hi");
        feed(8'h02, "R7 new pair lo");
        expect_val("R7 phase back to high", int'(sum_out), 16'h9B02);
        // flush in the same cycle as an edge: the byte wins
        feed(8'h10, "R7 hi");
        step(1'b0, 1'b1, 1'b1, 8'h20, "R7 edge beats flush");
        step(1'b0, 1'b0, 1'b0, 8'h00, "R7 release");
        expect_val("R7 edge beats flush sum", int'(sum_out), 16'hAB22);

        // R5: clear mid word and clear with an edge
        feed(8'h44, "R5 half word");
        step(1'b1, 1'b0, 1'b0, 8'h00, "R5 clear mid word");
        expect_val("R5 cleared", int'(sum_out), 0);
        feed(8'h01, "R5 hi after clear");
        feed(8'h02, "R5 lo after clear");
        expect_val("R5 phase reset", int'(sum_out), 16'h0102);
        step(1'b1, 1'b1, 1'b0, 8'h77, "R5 clear with edge");
        // R6: strobe held across the clear does not re-count
        step(1'b0, 1'b1, 1'b0, 8'h88, "R6 held after clear");
        step(1'b0, 1'b0, 1'b0, 8'h00, "R6 release");
        feed(8'h03, "R6 hi");
        feed(8'h04, "R6 lo");
        expect_val("R5 R6 dropped byte", int'(sum_out), 16'h0304);

        // R9: whole headers, valid and corrupted
        run_header(hdr_a, 1'b0, 0, "R9 hdr a valid");
        expect_val("R8 ok valid a", int'(sum_ok), 1);
        run_header(hdr_a, 1'b1, 15, "R9 hdr a corrupt");
        expect_val("R8 ok corrupt a", int'(sum_ok), 0);
        run_header(hdr_b, 1'b0, 0, "R9 hdr b valid");
        run_header(hdr_b, 1'b1, 3, "R9 hdr b corrupt");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule